// File: doc/BRIEF.md
# GPIO Port Interrupt Controller

An eight-line general-purpose I/O port with per-line interrupt detection. A byte-wide register strobe bus sets the output value and direction of each line, and it configures how every line raises an interrupt. Each input passes through a two-flop synchroniser. An optional filter can be switched on per line. The line is then checked against its trigger setting: level or edge, and high/rising or low/falling.

Edge events are held in a latch until software acknowledges them. It does this by writing ones to an acknowledge register. Level lines report the live qualified input. The enabled status of each line drives its own interrupt output, and the OR of all of them drives a combined output. The combined output suits a parent interrupt that is shared with another port.

The hardware does not detect both edges. Software gets that behaviour by flipping the polarity bit of a line after each acknowledge, so the block accepts polarity changes at run time.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, every configuration, data and direction register reads 0, `pin_oe` is 0 and no interrupt output is asserted.
- R2: `pin_out` follows the data register and `pin_oe` follows the direction register (1 = output). A read of the data register returns the register bit on output lines and the synchronised pin on input lines.
- R3: A line whose trigger-kind bit is 0 is level triggered. Its raw status is 1 while the qualified input equals its polarity bit (1 = high, 0 = low).
- R4: A line whose trigger-kind bit is 1 is edge triggered: polarity 1 catches a 0-to-1 change and polarity 0 catches a 1-to-0 change. An event caught on an enabled line stays in raw status until it is cleared.
- R5: Writing the acknowledge register clears the latched event of each line whose written bit is 1. Lines written with 0 keep their event.
- R6: Masked status is raw status AND enable. `irq_line[i]` equals masked bit i, and `irq_any` is the OR of all masked bits.
- R7: With its filter bit set, a line changes its qualified value only after the synchronised input has differed for 4 consecutive sample ticks, so a pulse shorter than that is ignored. With the bit clear, the synchronised input is used directly.
- R8: Clearing an enable bit, or writing a trigger-kind or polarity bit to a new value, discards the latched event of that line.
- R9: A polarity bit written at run time takes effect on the next change of the input. Flipping it after each acknowledge therefore catches both edges in turn.
- R10: Register byte addresses: trigger kind 0x00, polarity 0x04, acknowledge 0x08 (reads 0), enable 0x0C, masked status 0x10, raw status 0x14, filter 0x18, data 0x20, direction 0x24. In every register, bit i belongs to line i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 6 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pin_in | input | 8 | Asynchronous line inputs |
| pin_out | output | 8 | Output values of the lines |
| pin_oe | output | 8 | Output enables of the lines |
| irq_any | output | 1 | OR of all masked status bits |
| irq_line | output | 8 | Per-line interrupt, masked status |

## Verification
The assertions assume a single-cycle write strobe with address and data stable in the same cycle. They also assume the pins are the only asynchronous inputs. The bench drives every bus and pin change on the falling clock edge, keeps each write to one cycle and holds all pins at defined values throughout. The acknowledge and enable checks assume that an event arriving in the same cycle as its clear is kept. The stimulus avoids pin changes during those writes, so every expected status is unambiguous.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned GPIO_W = 8;
  localparam int unsigned ADDR_W = 6;

  typedef enum logic [ADDR_W-1:0] {
    REG_KIND  = 6'h00,
    REG_POL   = 6'h04,
    REG_ACK   = 6'h08,
    REG_EN    = 6'h0C,
    REG_MSTAT = 6'h10,
    REG_RSTAT = 6'h14,
    REG_FILT  = 6'h18,
    REG_DATA  = 6'h20,
    REG_DIR   = 6'h24
  } reg_sel_e;

  // level match: input equals requested polarity
  function automatic logic [GPIO_W-1:0] level_hits(input logic [GPIO_W-1:0] q,
                                                   input logic [GPIO_W-1:0] pol);
    return ~(q ^ pol);
  endfunction

  // edge match in the direction the polarity asks for
  function automatic logic [GPIO_W-1:0] edge_hits(input logic [GPIO_W-1:0] q,
                                                  input logic [GPIO_W-1:0] q_d,
                                                  input logic [GPIO_W-1:0] pol);
    return (q & ~q_d & pol) | (~q & q_d & ~pol);
  endfunction

  // bits a write moves to a new value
  function automatic logic [GPIO_W-1:0] changed_bits(input logic [GPIO_W-1:0] old_v,
                                                     input logic [GPIO_W-1:0] new_v);
    return old_v ^ new_v;
  endfunction
endpackage

// File: rtl/gpio_input_cond.sv
module gpio_input_cond #(
  parameter int unsigned N        = 8,
  parameter int unsigned TICK_DIV = 4,
  parameter int unsigned DB_TICKS = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_in,
  input  logic [N-1:0] filt_sel,
  output logic [N-1:0] sync_o,
  output logic [N-1:0] qual_o
);
  localparam int unsigned DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int unsigned CW = (DB_TICKS > 1) ? $clog2(DB_TICKS) : 1;

  logic [N-1:0]  s1, s2;
  logic [DW-1:0] div_q;
  logic          tick;
  logic [N-1:0]  filt_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= pin_in;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    div_q <= '0;
    else if (tick) div_q <= '0;
    else           div_q <= div_q + 1'b1;
  end
  assign tick = (div_q == DW'(TICK_DIV - 1));

  for (genvar g = 0; g < N; g++) begin : g_line
    logic [CW-1:0] run_q;
    logic          val_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run_q <= '0;
        val_q <= 1'b0;
      end else if (tick) begin
        if (s2[g] == val_q) begin
          run_q <= '0;
        end else if (run_q == CW'(DB_TICKS - 1)) begin
          val_q <= s2[g];
          run_q <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end
    end
    assign filt_v[g] = val_q;
  end

  assign sync_o = s2;
  assign qual_o = (filt_sel & filt_v) | (~filt_sel & s2);
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N = GPIO_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] qual,
  input  logic [N-1:0] kind,
  input  logic [N-1:0] pol,
  input  logic [N-1:0] en_gate,
  input  logic [N-1:0] drop,
  output logic [N-1:0] evt,
  output logic [N-1:0] latch,
  output logic [N-1:0] raw
);
  logic [N-1:0] q_d;

  assign evt = edge_hits(qual, q_d, pol) & kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_d   <= '0;
      latch <= '0;
    end else begin
      q_d   <= qual;
      latch <= ((latch & ~drop) | evt) & en_gate;
    end
  end

  assign raw = (kind & latch) | (~kind & level_hits(qual, pol));
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N        = GPIO_W,
  parameter int unsigned TICK_DIV = 4,
  parameter int unsigned DB_TICKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [N-1:0]      bus_wdata,
  output logic [N-1:0]      bus_rdata,
  input  logic [N-1:0]      pin_in,
  output logic [N-1:0]      pin_out,
  output logic [N-1:0]      pin_oe,
  output logic              irq_any,
  output logic [N-1:0]      irq_line
);
  logic [N-1:0] kind_q, pol_q, en_q, filt_q, dout_q, dir_q;
  logic [N-1:0] sync_v, qual_v;
  logic [N-1:0] evt, latch, raw, masked;
  logic [N-1:0] ack_bits, kind_chg, pol_chg, en_off, drop, en_gate;
  logic         wr_kind, wr_pol, wr_ack, wr_en, wr_filt, wr_data, wr_dir;

  assign wr_kind = bus_wr && (bus_addr == REG_KIND);
  assign wr_pol  = bus_wr && (bus_addr == REG_POL);
  assign wr_ack  = bus_wr && (bus_addr == REG_ACK);
  assign wr_en   = bus_wr && (bus_addr == REG_EN);
  assign wr_filt = bus_wr && (bus_addr == REG_FILT);
  assign wr_data = bus_wr && (bus_addr == REG_DATA);
  assign wr_dir  = bus_wr && (bus_addr == REG_DIR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= '0;
      pol_q  <= '0;
      en_q   <= '0;
      filt_q <= '0;
      dout_q <= '0;
      dir_q  <= '0;
    end else begin
      if (wr_kind) kind_q <= bus_wdata;
      if (wr_pol)  pol_q  <= bus_wdata;
      if (wr_en)   en_q   <= bus_wdata;
      if (wr_filt) filt_q <= bus_wdata;
      if (wr_data) dout_q <= bus_wdata;
      if (wr_dir)  dir_q  <= bus_wdata;
    end
  end

  // per-line discard sources for a pending edge
  assign ack_bits = wr_ack  ? bus_wdata : '0;
  assign kind_chg = wr_kind ? changed_bits(kind_q, bus_wdata) : '0;
  assign pol_chg  = wr_pol  ? changed_bits(pol_q, bus_wdata) : '0;
  assign en_off   = wr_en   ? (en_q & ~bus_wdata) : '0;
  assign drop     = ack_bits | kind_chg | pol_chg;
  assign en_gate  = en_q & ~en_off;

  gpio_input_cond #(.N(N), .TICK_DIV(TICK_DIV), .DB_TICKS(DB_TICKS)) u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   (pin_in),
    .filt_sel (filt_q),
    .sync_o   (sync_v),
    .qual_o   (qual_v)
  );

  gpio_irq_detect #(.N(N)) u_det (
    .clk     (clk),
    .rst_n   (rst_n),
    .qual    (qual_v),
    .kind    (kind_q),
    .pol     (pol_q),
    .en_gate (en_gate),
    .drop    (drop),
    .evt     (evt),
    .latch   (latch),
    .raw     (raw)
  );

  assign masked   = raw & en_q;
  assign irq_line = masked;
  assign irq_any  = |masked;
  assign pin_out  = dout_q;
  assign pin_oe   = dir_q;

  always_comb begin
    unique case (bus_addr)
      REG_KIND:  bus_rdata = kind_q;
      REG_POL:   bus_rdata = pol_q;
      REG_EN:    bus_rdata = en_q;
      REG_MSTAT: bus_rdata = masked;
      REG_RSTAT: bus_rdata = raw;
      REG_FILT:  bus_rdata = filt_q;
      REG_DATA:  bus_rdata = (dout_q & dir_q) | (sync_v & ~dir_q);
      REG_DIR:   bus_rdata = dir_q;
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
  parameter int unsigned N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_wr,
  input logic [5:0]   bus_addr,
  input logic [N-1:0] bus_wdata,
  input logic [N-1:0] en_q,
  input logic [N-1:0] evt,
  input logic [N-1:0] latch,
  input logic         irq_any,
  input logic [N-1:0] irq_line
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!irq_any && irq_line == '0));

  assert_edge_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt & en_q) && !(bus_wr && bus_addr == 6'h0C)) |=>
      (($past(evt & en_q) & ~latch) == '0));

  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 6'h08) |=> ((latch & $past(bus_wdata & ~evt)) == '0));

  assert_line_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_line & ~en_q) == '0);

  assert_any_is_or_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any == (|irq_line));

  assert_disable_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 6'h0C) |=> ((latch & ~$past(bus_wdata)) == '0));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .en_q      (en_q),
  .evt       (evt),
  .latch     (latch),
  .irq_any   (irq_any),
  .irq_line  (irq_line)
);

// File: tb/gpio_irq_port_test.sv
module gpio_irq_port_test;
  localparam logic [5:0] A_KIND = 6'h00, A_POL = 6'h04, A_ACK = 6'h08, A_EN = 6'h0C,
                         A_MST = 6'h10, A_RAW = 6'h14, A_FILT = 6'h18,
                         A_DATA = 6'h20, A_DIR = 6'h24;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out, pin_oe, irq_line;
  logic       irq_any;
  int         total = 0;
  int         bad = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  gpio_irq_port uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_any(irq_any), .irq_line(irq_line)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R1 irq_any", {7'd0, irq_any}, 8'h00);
    check("R1 pin_oe", pin_oe, 8'h00);
    rd(A_EN, v);   check("R1 enable", v, 8'h00);
    rd(A_KIND, v); check("R1 kind", v, 8'h00);
    rd(A_ACK, v);  check("R10 ack reads 0", v, 8'h00);
  endtask

  task automatic t_gpio;
    logic [7:0] v;
    wr(A_DIR, 8'hF0);
    wr(A_DATA, 8'hA5);
    pin_in = 8'h0C;
    wait_cyc(4);
    check("R2 pin_oe", pin_oe, 8'hF0);
    check("R2 pin_out", pin_out, 8'hA5);
    rd(A_DATA, v); check("R2 data read", v, 8'hAC);
    pin_in = 8'h00;
    wr(A_DIR, 8'h00);
    wait_cyc(4);
  endtask

  task automatic t_level;
    logic [7:0] v;
    wr(A_KIND, 8'h00);
    wr(A_POL, 8'h01);
    wr(A_EN, 8'h03);
    wait_cyc(4);
    rd(A_RAW, v); check("R3 raw low pins", v, 8'hFE);
    rd(A_MST, v); check("R6 masked", v, 8'h02);
    check("R6 irq_line", irq_line, 8'h02);
    pin_in = 8'h01; wait_cyc(4);
    rd(A_RAW, v); check("R3 raw line0 high", v, 8'hFF);
    check("R6 irq_line both", irq_line, 8'h03);
    pin_in = 8'h02; wait_cyc(4);
    rd(A_MST, v); check("R3 masked none", v, 8'h00);
    check("R6 irq_any low", {7'd0, irq_any}, 8'h00);
    wr(A_EN, 8'h00);
    pin_in = 8'h00; wait_cyc(4);
  endtask

  task automatic t_edge;
    logic [7:0] v;
    wr(A_KIND, 8'hFF);
    wr(A_POL, 8'h0F);
    wr(A_EN, 8'hFF);
    wait_cyc(5);
    rd(A_MST, v); check("R4 quiet", v, 8'h00);
    pin_in = 8'h11; wait_cyc(5);
    rd(A_MST, v); check("R4 rising line0 only", v, 8'h01);
    pin_in = 8'h00; wait_cyc(5);
    rd(A_MST, v); check("R4 falling line4 held", v, 8'h11);
    wr(A_ACK, 8'h10); wait_cyc(1);
    rd(A_MST, v); check("R5 ack line4 only", v, 8'h01);
    wr(A_ACK, 8'h01); wait_cyc(1);
    rd(A_RAW, v); check("R5 ack line0", v, 8'h00);
    check("R6 irq_any clear", {7'd0, irq_any}, 8'h00);
  endtask

  task automatic t_discard;
    logic [7:0] v;
    pin_in = 8'h02; wait_cyc(5);
    rd(A_MST, v); check("R8 line1 caught", v, 8'h02);
    wr(A_EN, 8'hFD);
    wr(A_EN, 8'hFF); wait_cyc(1);
    rd(A_MST, v); check("R8 disable drops", v, 8'h00);
    pin_in = 8'h06; wait_cyc(5);
    rd(A_RAW, v); check("R4 line2 caught", v, 8'h04);
    wr(A_POL, 8'h0B); wait_cyc(1);
    rd(A_RAW, v); check("R8 polarity write drops", v, 8'h00);
    wr(A_POL, 8'h0F);
    pin_in = 8'h00; wait_cyc(5);
    wr(A_ACK, 8'hFF);
  endtask

  task automatic t_both;
    logic [7:0] v;
    wr(A_EN, 8'h08);
    pin_in = 8'h08; wait_cyc(5);
    check("R9 rise seen", irq_line, 8'h08);
    wr(A_ACK, 8'h08);
    wr(A_POL, 8'h07); wait_cyc(1);
    check("R9 acked", irq_line, 8'h00);
    pin_in = 8'h00; wait_cyc(5);
    check("R9 fall seen after flip", irq_line, 8'h08);
    wr(A_ACK, 8'h08);
    wr(A_POL, 8'h0F);
    pin_in = 8'h08; wait_cyc(5);
    rd(A_MST, v); check("R9 rise again", v, 8'h08);
    wr(A_ACK, 8'h08);
    wr(A_EN, 8'h00);
    pin_in = 8'h00; wait_cyc(5);
  endtask

  task automatic t_filter;
    int seen;
    wr(A_KIND, 8'h00);
    wr(A_POL, 8'h20);
    wr(A_FILT, 8'h20);
    wr(A_EN, 8'h20);
    wait_cyc(30);
    check("R7 idle", {7'd0, irq_any}, 8'h00);
    seen = 0;
    pin_in = 8'h20;
    for (int i = 0; i < 6; i++) begin wait_cyc(1); if (irq_any) seen++; end
    pin_in = 8'h00;
    for (int i = 0; i < 40; i++) begin wait_cyc(1); if (irq_any) seen++; end
    check("R7 short pulse ignored", 8'(seen), 8'h00);
    pin_in = 8'h20; wait_cyc(40);
    check("R7 stable level passes", {7'd0, irq_any}, 8'h01);
    pin_in = 8'h00; wait_cyc(40);
    check("R7 release", {7'd0, irq_any}, 8'h00);
    wr(A_FILT, 8'h00);
    seen = 0;
    pin_in = 8'h20;
    for (int i = 0; i < 6; i++) begin wait_cyc(1); if (irq_any) seen++; end
    pin_in = 8'h00;
    wait_cyc(5);
    check("R7 unfiltered pulse seen", {7'd0, (seen > 0)}, 8'h01);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    t_reset();
    t_gpio();
    t_level();
    t_edge();
    t_discard();
    t_both();
    t_filter();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule